// File: doc/BRIEF.md
# Edge and Level Interrupt Delivery Engine

This block is the per-pin request and delivery core of an I/O interrupt router. Each input pin reports assertion and deassertion events. For each pin the block holds a request bit, a delivered-edge bit, a remote-IRR bit and a counter of successive end-of-interrupt (EOI) re-deliveries. The redirection entry of each pin is supplied on configuration inputs: mask, trigger mode, vector, destination, destination mode and delivery mode. When a pin needs service, the block emits one delivery message per cycle. A downstream acceptor answers in the same cycle with the number of destinations that took the message.

Edge-mode pins are delivered once per fresh assertion. If a pin is asserted again while its request is still pending, that assertion is reported as coalesced. Level-mode pins are held off by remote IRR. An EOI broadcast that matches their vector clears remote IRR and delivers them again if they are still asserted. A run of such immediate re-deliveries is cut off after a fixed count. At that point a shared timer re-injects the waiting level pins after a programmable number of cycles, which lets a misbehaving handler make slow progress. The first edge that sees the timer at zero pulses the re-injection. Every assertion and deassertion event returns a one-cycle status pulse that tells whether it was coalesced.

Top module: `irq_dispatch_core`

## Requirements
- R1: A deassertion event (line_evt=1, line_lvl=0) clears the pin's request bit. One cycle later it produces a status pulse with stat_valid=1 and stat_coalesced=0.
- R2: An assertion event on an edge-mode pin (cfg_level=0) whose request bit is clear sets the request bit. It clears the delivered-edge bit and reports stat_coalesced=0. The pin is delivered in the cycle after the event, and the delivered-edge bit is set after that delivery.
- R3: An assertion event on an edge-mode pin whose request bit is already set reports stat_coalesced=1. It clears the delivered-edge bit and delivers nothing. This also applies when the earlier edge was never delivered because the pin was masked.
- R4: A pin is never delivered while cfg_mask=1. A level-mode pin is never delivered while its remote-IRR bit is set. A blocked service request is dropped.
- R5: Delivering a level-mode pin (cfg_level=1) sets its remote-IRR bit only when dlv_accept_cnt is nonzero in the delivery cycle.
- R6: An EOI clears remote IRR on every pin whose cfg_vector equals eoi_vector. It must have eoi_valid=1 and eoi_level=1 (level trigger) and arrive while directed_eoi=0. An EOI with eoi_level=0, with directed_eoi=1 or with a non-matching vector changes nothing.
- R7: On a clearing EOI, an unmasked level pin whose request bit is set increments its storm counter and is delivered in the next cycle. A matching level pin that is masked or not requested resets its counter to 0.
- R8: When the increment would make the counter reach STORM_LIMIT, the counter clears and there is no immediate delivery. A re-injection is scheduled so that the pin is delivered DELAY_CYCLES+1 cycles after the EOI.
- R9: A re-injection requests service for every level-mode pin whose request bit is set and whose remote IRR is clear. Edge-mode pins are not affected.
- R10: At most one pin is delivered per cycle. When several pins wait, the lowest pin index is delivered first.
- R11: The delivery message carries the granted pin's index, vector, destination, destination mode and 3-bit delivery mode. dlv_level equals that pin's cfg_level.
- R12: After reset, all request, remote-IRR and delivered-edge bits are clear, and no delivery or status pulse is produced.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| line_evt | input | NPINS | Per-pin event strobe |
| line_lvl | input | NPINS | Level carried by the event (1 assert, 0 deassert) |
| cfg_mask | input | NPINS | Entry mask |
| cfg_level | input | NPINS | Entry trigger mode, 1 = level |
| cfg_dest_mode | input | NPINS | Entry destination mode |
| cfg_vector | input | NPINS*VEC_W | Entry vectors, pin i at bits i*VEC_W |
| cfg_dest | input | NPINS*DEST_W | Entry destinations, pin i at bits i*DEST_W |
| cfg_dlv_mode | input | NPINS*3 | Entry delivery modes, pin i at bits i*3 |
| directed_eoi | input | 1 | Directed-EOI mode; suppresses broadcast EOI handling |
| eoi_valid | input | 1 | EOI broadcast strobe |
| eoi_level | input | 1 | Trigger mode of the EOI, 1 = level |
| eoi_vector | input | VEC_W | Vector of the EOI |
| dlv_valid | output | 1 | Delivery message valid |
| dlv_pin | output | PIN_W | Pin being delivered |
| dlv_vector | output | VEC_W | Message vector |
| dlv_dest | output | DEST_W | Message destination |
| dlv_dest_mode | output | 1 | Message destination mode |
| dlv_mode | output | 3 | Message delivery mode |
| dlv_level | output | 1 | Message trigger mode |
| dlv_accept_cnt | input | ACC_W | Destinations that accepted the message, same cycle |
| stat_valid | output | NPINS | Per-pin event status pulse |
| stat_coalesced | output | NPINS | Event was coalesced |
| req_state | output | NPINS | Request bits |
| rirr_state | output | NPINS | Remote-IRR bits |
| edge_done_state | output | NPINS | Delivered-edge bits |

## Verification
Timing is counted from the cycle in which an input is driven:
- Event status pulses and request-bit changes are visible one cycle after a pin event.
- A fresh edge or level assertion is delivered one cycle after its event, and a clearing EOI re-delivers one cycle after the EOI.
- A throttled EOI re-delivers exactly DELAY_CYCLES+1 cycles after the EOI.
- Pins that wait together come out in consecutive cycles, in index order.

The bench records the cycle number of every delivery at the falling edge and compares it with these offsets. It checks that nothing was delivered one cycle before the re-injection is due. It sweeps edge and level pins, masked and unmasked entries, zero and nonzero accept counts, and EOIs with matching and non-matching vectors, with and without directed mode. In each case the expected counts and cycles are computed from the offsets above.

// File: rtl/irqd_pkg.sv
package irqd_pkg;
  typedef enum logic {
    TRIG_EDGE  = 1'b0,
    TRIG_LEVEL = 1'b1
  } trig_e;

  localparam int DLV_MODE_W = 3;
endpackage

// File: rtl/irqd_pin_ctrl.sv
module irqd_pin_ctrl #(
  parameter int VEC_W       = 8,
  parameter int STORM_LIMIT = 10000
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             evt,
  input  logic             lvl,
  input  logic             cfg_mask,
  input  logic             cfg_level,
  input  logic [VEC_W-1:0] cfg_vec,
  input  logic             eoi_valid,
  input  logic             eoi_level,
  input  logic [VEC_W-1:0] eoi_vec,
  input  logic             directed_eoi,
  input  logic             grant,
  input  logic             accept_nz,
  input  logic             reinject,
  output logic             req_o,
  output logic             rirr_o,
  output logic             done_o,
  output logic             svc_o,
  output logic             ready_o,
  output logic             storm_o,
  output logic             stat_v_o,
  output logic             stat_c_o
);
  localparam int CNT_W = $clog2(STORM_LIMIT + 1);
  localparam logic [CNT_W-1:0] LIM_M1 = CNT_W'(STORM_LIMIT - 1);

  logic             irr_q, irr_d;
  logic             rirr_q, rirr_d;
  logic             done_q, done_d;
  logic             svc_q, svc_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             stv_q, stc_q;

  logic assert_evt, coal, eoi_hit, lvl_hit, redo, at_lim, deliver, svc_set;

  always_comb begin
    assert_evt = evt & lvl;
    coal       = assert_evt & ~cfg_level & irr_q;
    eoi_hit    = eoi_valid & eoi_level & ~directed_eoi & (cfg_vec == eoi_vec);
    lvl_hit    = eoi_hit & cfg_level;
    redo       = lvl_hit & ~cfg_mask & irr_q;
    at_lim     = (cnt_q == LIM_M1);
    ready_o    = svc_q & ~cfg_mask & ~(cfg_level & rirr_q);
    deliver    = grant & ready_o;
    storm_o    = redo & at_lim;
  end

  always_comb begin
    irr_d = irr_q;
    if (evt) irr_d = lvl;

    done_d = done_q;
    if (deliver & ~cfg_level) done_d = 1'b1;
    if (assert_evt & ~cfg_level) done_d = 1'b0;

    rirr_d = rirr_q;
    if (eoi_hit) rirr_d = 1'b0;
    if (deliver & cfg_level & accept_nz) rirr_d = 1'b1;
    if (~cfg_level) rirr_d = 1'b0;

    cnt_d = cnt_q;
    if (lvl_hit) begin
      if (redo && !at_lim) cnt_d = cnt_q + 1'b1;
      else                 cnt_d = '0;
    end

    svc_set = (assert_evt & ~coal) | (redo & ~at_lim)
            | (reinject & cfg_level & irr_q & ~rirr_q);
    svc_d   = svc_set | (svc_q & ~grant);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irr_q  <= 1'b0;
      rirr_q <= 1'b0;
      done_q <= 1'b0;
      svc_q  <= 1'b0;
      cnt_q  <= '0;
      stv_q  <= 1'b0;
      stc_q  <= 1'b0;
    end else begin
      irr_q  <= irr_d;
      rirr_q <= rirr_d;
      done_q <= done_d;
      svc_q  <= svc_d;
      cnt_q  <= cnt_d;
      stv_q  <= evt;
      stc_q  <= coal;
    end
  end

  assign req_o    = irr_q;
  assign rirr_o   = rirr_q;
  assign done_o   = done_q;
  assign svc_o    = svc_q;
  assign stat_v_o = stv_q;
  assign stat_c_o = stc_q;

  // R5
  rirr_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rirr_q) |-> $past(grant && cfg_level && accept_nz));
  // R2
  done_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done_q) |-> $past(grant && !cfg_level));
  // R3
  coal_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stc_q |-> (stv_q && !done_q));
  // R8
  cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= LIM_M1);
endmodule

// File: rtl/irqd_arbiter.sv
module irqd_arbiter #(
  parameter int N = 24,
  localparam int PIN_W = (N > 1) ? $clog2(N) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N-1:0]     req,
  output logic [N-1:0]     grant,
  output logic [PIN_W-1:0] idx,
  output logic             any
);
  logic [N:0] lower;

  assign lower[0] = 1'b0;
  for (genvar i = 0; i < N; i++) begin : g_chain
    assign grant[i]     = req[i] & ~lower[i];
    assign lower[i + 1] = lower[i] | req[i];
  end
  assign any = lower[N];

  always_comb begin
    idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req[i]) idx = PIN_W'(i);
    end
  end

  // R10
  grant_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant) && ((grant & ~req) == '0));
  // R10
  grant_idx_chk: assert property (@(posedge clk) disable iff (!rst_n)
    any |-> grant[idx]);
endmodule

// File: rtl/irqd_delay_timer.sv
module irqd_delay_timer #(
  parameter int DELAY_CYCLES = 500000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic fire
);
  localparam int DW = $clog2(DELAY_CYCLES + 1);
  localparam logic [DW-1:0] LOAD = DW'(DELAY_CYCLES - 1);

  logic          armed_q, armed_d;
  logic [DW-1:0] cnt_q, cnt_d;

  assign fire = armed_q & (cnt_q == '0);

  always_comb begin
    armed_d = armed_q;
    cnt_d   = cnt_q;
    if (armed_q && !fire) begin
      cnt_d = cnt_q - 1'b1;
    end else if (start) begin
      armed_d = 1'b1;
      cnt_d   = LOAD;
    end else if (fire) begin
      armed_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed_q <= 1'b0;
      cnt_q   <= '0;
    end else begin
      armed_q <= armed_d;
      cnt_q   <= cnt_d;
    end
  end

  // R8
  fire_armed_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fire |-> $past(armed_q));
endmodule

// File: rtl/irq_dispatch_core.sv
module irq_dispatch_core
  import irqd_pkg::*;
#(
  parameter int NPINS        = 24,
  parameter int VEC_W        = 8,
  parameter int DEST_W       = 8,
  parameter int ACC_W        = 8,
  parameter int STORM_LIMIT  = 10000,
  parameter int DELAY_CYCLES = 500000,
  localparam int PIN_W = (NPINS > 1) ? $clog2(NPINS) : 1
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [NPINS-1:0]            line_evt,
  input  logic [NPINS-1:0]            line_lvl,
  input  logic [NPINS-1:0]            cfg_mask,
  input  logic [NPINS-1:0]            cfg_level,
  input  logic [NPINS-1:0]            cfg_dest_mode,
  input  logic [NPINS*VEC_W-1:0]      cfg_vector,
  input  logic [NPINS*DEST_W-1:0]     cfg_dest,
  input  logic [NPINS*DLV_MODE_W-1:0] cfg_dlv_mode,
  input  logic                        directed_eoi,
  input  logic                        eoi_valid,
  input  logic                        eoi_level,
  input  logic [VEC_W-1:0]            eoi_vector,
  output logic                        dlv_valid,
  output logic [PIN_W-1:0]            dlv_pin,
  output logic [VEC_W-1:0]            dlv_vector,
  output logic [DEST_W-1:0]           dlv_dest,
  output logic                        dlv_dest_mode,
  output logic [DLV_MODE_W-1:0]       dlv_mode,
  output logic                        dlv_level,
  input  logic [ACC_W-1:0]            dlv_accept_cnt,
  output logic [NPINS-1:0]            stat_valid,
  output logic [NPINS-1:0]            stat_coalesced,
  output logic [NPINS-1:0]            req_state,
  output logic [NPINS-1:0]            rirr_state,
  output logic [NPINS-1:0]            edge_done_state
);
  logic [NPINS-1:0] svc, ready, storm, grant;
  logic [PIN_W-1:0] gidx;
  logic             gany, accept_nz, reinject;
  trig_e            gtrig;

  assign accept_nz = |dlv_accept_cnt;

  for (genvar i = 0; i < NPINS; i++) begin : g_pin
    irqd_pin_ctrl #(
      .VEC_W       (VEC_W),
      .STORM_LIMIT (STORM_LIMIT)
    ) u_pin (
      .clk          (clk),
      .rst_n        (rst_n),
      .evt          (line_evt[i]),
      .lvl          (line_lvl[i]),
      .cfg_mask     (cfg_mask[i]),
      .cfg_level    (cfg_level[i]),
      .cfg_vec      (cfg_vector[i*VEC_W +: VEC_W]),
      .eoi_valid    (eoi_valid),
      .eoi_level    (eoi_level),
      .eoi_vec      (eoi_vector),
      .directed_eoi (directed_eoi),
      .grant        (grant[i]),
      .accept_nz    (accept_nz),
      .reinject     (reinject),
      .req_o        (req_state[i]),
      .rirr_o       (rirr_state[i]),
      .done_o       (edge_done_state[i]),
      .svc_o        (svc[i]),
      .ready_o      (ready[i]),
      .storm_o      (storm[i]),
      .stat_v_o     (stat_valid[i]),
      .stat_c_o     (stat_coalesced[i])
    );
  end

  irqd_arbiter #(.N(NPINS)) u_arb (
    .clk   (clk),
    .rst_n (rst_n),
    .req   (svc),
    .grant (grant),
    .idx   (gidx),
    .any   (gany)
  );

  irqd_delay_timer #(.DELAY_CYCLES(DELAY_CYCLES)) u_timer (
    .clk   (clk),
    .rst_n (rst_n),
    .start (|storm),
    .fire  (reinject)
  );

  always_comb begin
    gtrig         = trig_e'(cfg_level[gidx]);
    dlv_valid     = gany & |(grant & ready);
    dlv_pin       = gidx;
    dlv_vector    = cfg_vector[gidx*VEC_W +: VEC_W];
    dlv_dest      = cfg_dest[gidx*DEST_W +: DEST_W];
    dlv_dest_mode = cfg_dest_mode[gidx];
    dlv_mode      = cfg_dlv_mode[gidx*DLV_MODE_W +: DLV_MODE_W];
    dlv_level     = (gtrig == TRIG_LEVEL);
  end

  // R4
  masked_dlv_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dlv_valid |-> !cfg_mask[dlv_pin]);
  // R4
  rirr_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dlv_valid && dlv_level) |-> !rirr_state[dlv_pin]);
  // R12
  quiet_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (req_state == '0 && rirr_state == '0 && !dlv_valid));
endmodule

// File: tb/tb_irq_dispatch_core.sv
`timescale 1ns/1ps
module tb_irq_dispatch_core;
  localparam int NP = 4;
  localparam int D  = 12;

  logic              clk = 1'b0;
  logic              rst_n;
  logic [NP-1:0]     line_evt, line_lvl, cfg_mask, cfg_level, cfg_dest_mode;
  logic [NP*8-1:0]   cfg_vector, cfg_dest;
  logic [NP*3-1:0]   cfg_dlv_mode;
  logic              directed_eoi, eoi_valid, eoi_level;
  logic [7:0]        eoi_vector;
  logic              dlv_valid, dlv_dest_mode, dlv_level;
  logic [1:0]        dlv_pin;
  logic [7:0]        dlv_vector, dlv_dest;
  logic [2:0]        dlv_mode;
  logic [3:0]        dlv_accept_cnt, acc_cfg;
  logic [NP-1:0]     stat_valid, stat_coalesced, req_state, rirr_state, edge_done_state;

  int cyc = 0, nchk = 0, nfail = 0, t0 = 0;
  bit finished = 0;
  int dcount[NP], dcyc[NP], svalid[NP], scoal[NP];
  int lvec[NP], ldest[NP], ldm[NP], lmode[NP], llvl[NP];

  always #10 clk = ~clk;

  irq_dispatch_core #(.NPINS(NP), .VEC_W(8), .DEST_W(8), .ACC_W(4),
                      .STORM_LIMIT(3), .DELAY_CYCLES(D)) dut (.*);

  assign dlv_accept_cnt = dlv_valid ? acc_cfg : 4'd0;

  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) begin
    if (rst_n && dlv_valid) begin
      dcount[dlv_pin]++;
      dcyc[dlv_pin]  = cyc;
      lvec[dlv_pin]  = dlv_vector;
      ldest[dlv_pin] = dlv_dest;
      ldm[dlv_pin]   = dlv_dest_mode;
      lmode[dlv_pin] = dlv_mode;
      llvl[dlv_pin]  = dlv_level;
    end
    for (int p = 0; p < NP; p++) begin
      if (stat_valid[p])     svalid[p]++;
      if (stat_coalesced[p]) scoal[p]++;
    end
  end

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    #5;
  endtask

  task automatic chk(input string tag, input int act, input int exp);
    nchk++;
    if (act != exp) begin
      nfail++;
      $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
    end
  endtask

  task automatic ev(input logic [NP-1:0] m, input logic [NP-1:0] l);
    t0 = cyc;
    line_evt = m;
    line_lvl = l;
    step(1);
    line_evt = '0;
  endtask

  task automatic eoi(input logic [7:0] v, input logic lv, input logic dir);
    t0 = cyc;
    eoi_vector = v; eoi_level = lv; directed_eoi = dir; eoi_valid = 1'b1;
    step(1);
    eoi_valid = 1'b0; directed_eoi = 1'b0;
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nfail++;
    $display("FAIL watchdog act=timeout exp=finish");
    summary();
  end

  initial begin
    for (int p = 0; p < NP; p++) begin
      dcount[p] = 0; dcyc[p] = 0; svalid[p] = 0; scoal[p] = 0;
    end
    rst_n = 1'b0;
    line_evt = '0; line_lvl = '0; cfg_mask = '1; cfg_level = '0;
    cfg_dest_mode = 4'b0101;
    cfg_vector    = {8'h30, 8'h30, 8'h21, 8'h20};
    cfg_dest      = {8'h43, 8'h42, 8'h41, 8'h40};
    cfg_dlv_mode  = {3'd3, 3'd2, 3'd1, 3'd0};
    directed_eoi = 1'b0; eoi_valid = 1'b0; eoi_level = 1'b0; eoi_vector = '0;
    acc_cfg = 4'd1;
    step(3);
    rst_n = 1'b1;
    step(1);
    // R12 reset state
    chk("R12 req", int'(req_state), 0);
    chk("R12 rirr", int'(rirr_state), 0);
    chk("R12 done", int'(edge_done_state), 0);
    chk("R12 stat", int'(stat_valid), 0);
    chk("R12 dlv", int'(dlv_valid), 0);

    cfg_mask = 4'b0000;
    cfg_level = 4'b1100;
    step(1);

    // R2 fresh edge on pin 0
    ev(4'b0001, 4'b0001);
    chk("R2 req set", int'(req_state[0]), 1);
    chk("R2 stat valid", int'(stat_valid[0]), 1);
    chk("R2 stat coal", int'(stat_coalesced[0]), 0);
    step(2);
    chk("R2 count", dcount[0], 1);
    chk("R2 cycle", dcyc[0], t0 + 1);
    chk("R2 done set", int'(edge_done_state[0]), 1);
    // R11 message fields of pin 0
    chk("R11 vec", lvec[0], 'h20);
    chk("R11 dest", ldest[0], 'h40);
    chk("R11 dm", ldm[0], 1);
    chk("R11 mode", lmode[0], 0);
    chk("R11 lvl", llvl[0], 0);

    // R3 repeat assertion while request set
    ev(4'b0001, 4'b0001);
    step(2);
    chk("R3 coal", scoal[0], 1);
    chk("R3 no dlv", dcount[0], 1);
    chk("R3 done clr", int'(edge_done_state[0]), 0);

    // R1 deassert
    ev(4'b0001, 4'b0000);
    chk("R1 req clr", int'(req_state[0]), 0);
    chk("R1 stat coal", int'(stat_coalesced[0]), 0);
    step(1);
    chk("R1 stat cnt", svalid[0], 3);

    // R4 masked edge, then R3 coalesced after undelivered edge
    cfg_mask[0] = 1'b1;
    ev(4'b0001, 4'b0001);
    step(2);
    chk("R4 masked no dlv", dcount[0], 1);
    chk("R4 masked req", int'(req_state[0]), 1);
    ev(4'b0001, 4'b0001);
    step(1);
    cfg_mask[0] = 1'b0;
    ev(4'b0001, 4'b0001);
    step(2);
    chk("R3 undelivered coal", scoal[0], 3);
    chk("R3 undelivered no dlv", dcount[0], 1);
    ev(4'b0001, 4'b0000);
    step(1);

    // R5 level pin 2, zero accept then nonzero
    acc_cfg = 4'd0;
    ev(4'b0100, 4'b0100);
    step(2);
    chk("R5 dlv", dcount[2], 1);
    chk("R5 cycle", dcyc[2], t0 + 1);
    chk("R5 no accept rirr", int'(rirr_state[2]), 0);
    chk("R11 lvl fields", (lvec[2] << 8) | (lmode[2] << 1) | llvl[2], 'h3005);
    acc_cfg = 4'd1;
    ev(4'b0100, 4'b0100);
    step(2);
    chk("R5 dlv2", dcount[2], 2);
    chk("R5 rirr set", int'(rirr_state[2]), 1);
    ev(4'b0100, 4'b0100);
    step(2);
    chk("R4 rirr blocks", dcount[2], 2);

    // R6 pin 3 shares vector 0x30
    ev(4'b1000, 4'b1000);
    step(2);
    chk("R6 p3 dlv", dcount[3], 1);
    eoi(8'h30, 1'b1, 1'b1);
    step(2);
    eoi(8'h30, 1'b0, 1'b0);
    step(2);
    eoi(8'h31, 1'b1, 1'b0);
    step(2);
    chk("R6 ignored rirr", int'(rirr_state), 'b1100);
    chk("R6 ignored dlv", dcount[2] + dcount[3], 3);

    // R6 R7 R10 clearing EOI
    eoi(8'h30, 1'b1, 1'b0);
    chk("R6 rirr clr", int'(rirr_state), 0);
    step(3);
    chk("R7 p2 redlv", dcyc[2], t0 + 1);
    chk("R10 p3 after p2", dcyc[3], t0 + 2);
    chk("R7 counts", dcount[2] * 10 + dcount[3], 32);
    eoi(8'h30, 1'b1, 1'b0);
    step(3);
    chk("R7 second", dcount[2] * 10 + dcount[3], 43);

    // R9 setup: pin 1 edge with undelivered request
    cfg_mask[1] = 1'b1;
    ev(4'b0010, 4'b0010);
    step(2);
    cfg_mask[1] = 1'b0;

    // R8 storm threshold
    eoi(8'h30, 1'b1, 1'b0);
    step(D - 1);
    chk("R8 no early dlv", dcount[2] * 10 + dcount[3], 43);
    chk("R8 rirr clr", int'(rirr_state), 0);
    step(4);
    chk("R8 reinject p2", dcyc[2], t0 + D + 1);
    chk("R9 reinject p3", dcyc[3], t0 + D + 2);
    chk("R9 counts", dcount[2] * 10 + dcount[3], 54);
    chk("R9 edge untouched", dcount[1], 0);

    // R7 counter reset by masked / idle match
    ev(4'b1000, 4'b0000);
    step(1);
    eoi(8'h30, 1'b1, 1'b0);
    step(3);
    chk("R7 p2 only", dcount[2] * 10 + dcount[3], 64);
    chk("R7 p3 rirr clr", int'(rirr_state[3]), 0);
    cfg_mask[2] = 1'b1;
    eoi(8'h30, 1'b1, 1'b0);
    step(3);
    chk("R7 masked no dlv", dcount[2], 6);
    cfg_mask[2] = 1'b0;
    step(2);
    chk("R7 unmask quiet", dcount[2], 6);
    eoi(8'h30, 1'b1, 1'b0);
    step(3);
    eoi(8'h30, 1'b1, 1'b0);
    step(3);
    chk("R7 count restarted", dcount[2], 8);
    eoi(8'h30, 1'b1, 1'b0);
    step(3);
    chk("R8 throttled", dcount[2], 8);
    step(D + 2);
    chk("R8 reinject later", dcount[2], 9);
    chk("R9 idle p3", dcount[3], 4);

    // R10 two edges in one cycle
    ev(4'b0011, 4'b0000);
    step(1);
    ev(4'b0011, 4'b0011);
    step(3);
    chk("R10 p0 first", dcyc[0], t0 + 1);
    chk("R10 p1 second", dcyc[1], t0 + 2);

    summary();
  end
endmodule